// File: doc/BRIEF.md
# Modular-Exponentiation Operand Loader and Control Front-End

This block sits between a host register bus and an external modular-exponentiation core. Software sets a memory base address, a transfer length in bytes and the exponent and modulus bit counts. It then writes the trigger register. The block fetches the operand image from system memory one 32-bit word at a time through a read-master port and stores each word in a local operand SRAM of 1536 dwords. When the load ends, and if software asked for it, the block sends the core a one-cycle start pulse. When the core reports completion, the block latches an interrupt status flag that the host clears by writing a one to it.

The SRAM interleaves three operand classes: exponent, modulus and data. A group of twelve dwords holds four words of each class, exponent first, then modulus, then data. A command bit decides who owns the memory. When the bit is set, the host reads and writes the SRAM through an address window. When the bit is clear, the core owns the memory through a class-and-index port, and the window reads as zero.

Top module: `rsa_dma_front`

## Requirements
- R1: After reset, every register reads 0, and `irq`, `rd_req` and `core_start` are low.
- R2: Every register reads back the value written to it: command (0x048), source base (0x04C), byte length (0x050), key length (0x058) and interrupt mask (0x3F8). The key length drives `core_exp_bits` from bits [31:16] and `core_mod_bits` from bits [15:0].
- R3: Writing trigger (0x000) with bit 1 set while idle starts a load. The load has N = min(length/4, 1536) reads, and read k uses address base+4k. `rd_req` and `rd_addr` stay steady until `rd_valid` arrives, and each accepted word goes into SRAM word k. Words at index N and above keep their contents.
- R4: `core_start` is a single-cycle pulse. It is never asserted while a load is in progress. It fires once after the load if trigger bit 0 was also set, and never if bit 0 was clear. A trigger write with only bit 0 set pulses `core_start` in the cycle after the write.
- R5: `core_done` sets status bit 1 (0x3FC) only while the core is running. A `core_done` received while idle or loading is ignored.
- R6: Writing a one to status bit 1 clears it, and writing a zero leaves it unchanged. If the clear comes in the same cycle that `core_done` sets the bit, the bit stays set.
- R7: `irq` is high exactly when status bit 1 and mask bit 1 are both set.
- R8: A nonzero trigger write received while a load or a run is in progress is ignored. A write of 0 aborts the operation at once: `rd_req` drops, no start follows, and a later trigger is accepted.
- R9: Host addresses with bit 13 set reach SRAM word addr[12:2]. When command bit 8 is 1, the host reads and writes the SRAM through this window. When command bit 8 is 0, reads return 0 and writes are dropped. Words beyond 1535 always read 0.
- R10: The engine port maps class c (0 exponent, 1 modulus, 2 data) and index i to SRAM word (i/4)*12 + 4c + i%4. Engine writes take effect only when command bit 8 is 0.
- R11: While an operation is in progress, the trigger register reads back the accepted bits [1:0]. It reads 0 once the block is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | 14 | Host byte address; bit 13 selects the SRAM window |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Host read data for `bus_addr` (combinational) |
| rd_req | output | 1 | Read-master request |
| rd_addr | output | 32 | Read-master byte address |
| rd_valid | input | 1 | Read data valid; accepts the current request |
| rd_data | input | 32 | Read data |
| core_start | output | 1 | One-cycle start pulse to the core |
| core_done | input | 1 | Core completion |
| core_exp_bits | output | 16 | Exponent length in bits |
| core_mod_bits | output | 16 | Modulus length in bits |
| eng_cls | input | 2 | Engine operand class |
| eng_idx | input | 9 | Engine word index within the class |
| eng_we | input | 1 | Engine write enable |
| eng_wdata | input | 32 | Engine write data |
| eng_rdata | output | 32 | Engine read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can act on the same cycle: completion from the core can set the status flag while a host write-one-to-clear targets it. The bench provokes this by raising `core_done` and the status write together during a run. It then reads status back and expects the flag to be set, because setting takes priority. The SRAM ownership switch is exercised in a similar way: a host write made while the engine owns the memory must not appear when the host later reads that word back in host mode.

// File: rtl/rsa_dma_front.sv
module rsa_dma_front #(
  parameter int CLASS_DWORDS = 512,
  parameter int ADDR_W = 14,
  localparam int IDX_W = $clog2(CLASS_DWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              rd_req,
  output logic [31:0]       rd_addr,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data,
  output logic              core_start,
  input  logic              core_done,
  output logic [15:0]       core_exp_bits,
  output logic [15:0]       core_mod_bits,
  input  logic [1:0]        eng_cls,
  input  logic [IDX_W-1:0]  eng_idx,
  input  logic              eng_we,
  input  logic [31:0]       eng_wdata,
  output logic [31:0]       eng_rdata,
  output logic              irq
);
  localparam int MEM_DWORDS = 3 * CLASS_DWORDS;
  localparam int MA_W = $clog2(MEM_DWORDS);
  localparam int GROUP = 12;
  localparam int SLICE = 4;
  localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'('h048);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'('h04C);
  localparam logic [ADDR_W-1:0] A_LEN  = ADDR_W'('h050);
  localparam logic [ADDR_W-1:0] A_KLEN = ADDR_W'('h058);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'('h3F8);
  localparam logic [ADDR_W-1:0] A_STS  = ADDR_W'('h3FC);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_RUN} st_t;

  st_t         st_q;
  logic [31:0] cmd_q, base_q, len_q, klen_q, mask_q;
  logic        sts_q, go_q, start_q;
  logic [1:0]  trig_q;
  logic [MA_W:0] cnt_q, nwords_q;
  logic [31:0] mem [MEM_DWORDS];

  wire host_mode = cmd_q[8];
  wire is_mem = bus_addr[ADDR_W-1];
  wire [MA_W-1:0] host_w = bus_addr[MA_W+1:2];
  wire host_ok = is_mem && host_mode && (host_w < MA_W'(MEM_DWORDS));
  wire running = (st_q == S_RUN);

  wire wr_trig = bus_wr && bus_addr == A_TRIG;
  wire trig_stop = wr_trig && bus_wdata == 32'd0;
  wire trig_go = wr_trig && bus_wdata[1:0] != 2'b00 && st_q == S_IDLE;
  wire load_end = (st_q == S_LOAD) && (cnt_q == nwords_q);
  wire beat = rd_req && rd_valid;

  wire [31:0] req_words = {2'b00, len_q[31:2]};
  wire [MA_W:0] clip_words = (req_words > 32'(MEM_DWORDS)) ? (MA_W+1)'(MEM_DWORDS)
                                                          : req_words[MA_W:0];

  wire eng_ok = (eng_cls != 2'd3);
  wire [MA_W-1:0] eng_w = MA_W'(eng_idx >> 2) * MA_W'(GROUP)
                        + MA_W'(eng_cls) * MA_W'(SLICE) + MA_W'(eng_idx[1:0]);

  assign rd_req = (st_q == S_LOAD) && (cnt_q != nwords_q);
  assign rd_addr = base_q + (32'(cnt_q) << 2);
  assign core_start = start_q;
  assign core_exp_bits = klen_q[31:16];
  assign core_mod_bits = klen_q[15:0];
  assign irq = sts_q && mask_q[1];
  assign eng_rdata = eng_ok ? mem[eng_w] : 32'd0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      cmd_q <= '0; base_q <= '0; len_q <= '0; klen_q <= '0; mask_q <= '0;
      sts_q <= 1'b0; go_q <= 1'b0; start_q <= 1'b0; trig_q <= '0;
      cnt_q <= '0; nwords_q <= '0;
    end else begin
      start_q <= 1'b0;
      if (bus_wr && bus_addr == A_CMD)  cmd_q  <= bus_wdata;
      if (bus_wr && bus_addr == A_BASE) base_q <= bus_wdata;
      if (bus_wr && bus_addr == A_LEN)  len_q  <= bus_wdata;
      if (bus_wr && bus_addr == A_KLEN) klen_q <= bus_wdata;
      if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata;
      if (running && core_done) sts_q <= 1'b1;
      else if (bus_wr && bus_addr == A_STS && bus_wdata[1]) sts_q <= 1'b0;

      if (trig_stop) begin
        st_q <= S_IDLE; trig_q <= '0; go_q <= 1'b0;
      end else begin
        case (st_q)
          S_IDLE: if (trig_go) begin
            trig_q <= bus_wdata[1:0];
            go_q <= bus_wdata[0];
            if (bus_wdata[1]) begin
              st_q <= S_LOAD; cnt_q <= '0; nwords_q <= clip_words;
            end else begin
              st_q <= S_RUN; start_q <= 1'b1;
            end
          end
          S_LOAD: if (load_end) begin
            if (go_q) begin st_q <= S_RUN; start_q <= 1'b1; end
            else begin st_q <= S_IDLE; trig_q <= '0; end
          end else if (beat) cnt_q <= cnt_q + 1'b1;
          S_RUN: if (core_done) begin st_q <= S_IDLE; trig_q <= '0; end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if ((st_q == S_LOAD) && beat)
      mem[cnt_q[MA_W-1:0]] <= rd_data;
    else if (!host_mode && eng_we && eng_ok && st_q != S_LOAD)
      mem[eng_w] <= eng_wdata;
    else if (bus_wr && host_ok)
      mem[host_w] <= bus_wdata;
  end

  always_comb begin
    bus_rdata = 32'd0;
    if (is_mem) begin
      if (host_ok) bus_rdata = mem[host_w];
    end else begin
      case (bus_addr)
        A_TRIG: bus_rdata = {30'd0, trig_q};
        A_CMD:  bus_rdata = cmd_q;
        A_BASE: bus_rdata = base_q;
        A_LEN:  bus_rdata = len_q;
        A_KLEN: bus_rdata = klen_q;
        A_MASK: bus_rdata = mask_q;
        A_STS:  bus_rdata = {30'd0, sts_q, 1'b0};
        default: bus_rdata = 32'd0;
      endcase
    end
  end
endmodule

// File: rtl/rsa_dma_front_chk.sv
module rsa_dma_front_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [31:0]       rd_addr,
  input logic              core_start,
  input logic              core_done,
  input logic              running,
  input logic              sts
);
  wire trig_wr = bus_wr && bus_addr == ADDR_W'('h000);
  wire sts_clr = bus_wr && bus_addr == ADDR_W'('h3FC) && bus_wdata[1];

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start); // R4
  AST_NO_START_IN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !core_start); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid && !trig_wr) |=> (rd_req && $stable(rd_addr))); // R3
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_valid) |=> (!rd_req || rd_addr == $past(rd_addr) + 32'd4)); // R3
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (running && core_done) |=> sts); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr && !(running && core_done)) |=> !sts); // R6
  AST_STOP_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_wr && bus_wdata == 32'd0) |=> (!rd_req && !core_start)); // R8
endmodule

bind rsa_dma_front rsa_dma_front_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rd_req(rd_req), .rd_valid(rd_valid),
  .rd_addr(rd_addr), .core_start(core_start), .core_done(core_done),
  .running(running), .sts(sts_q)
);

// File: tb/test_rsa_dma_front.sv
module test_rsa_dma_front;
  localparam int MW = 1536;
  localparam logic [13:0] A_TRIG = 14'h000, A_CMD = 14'h048, A_BASE = 14'h04C,
                          A_LEN = 14'h050, A_KLEN = 14'h058, A_MASK = 14'h3F8,
                          A_STS = 14'h3FC;

  logic clk = 0;
  always #5 clk = ~clk;

  logic rst_n = 0, bus_wr = 0, rd_valid = 0, core_done = 0, eng_we = 0;
  logic [13:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, rd_data = 0, eng_wdata = 0;
  logic [1:0] eng_cls = 0;
  logic [8:0] eng_idx = 0;
  logic [31:0] bus_rdata, rd_addr, eng_rdata;
  logic rd_req, core_start, irq;
  logic [15:0] core_exp_bits, core_mod_bits;

  rsa_dma_front i_rsa_dma_front (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .core_start(core_start), .core_done(core_done),
    .core_exp_bits(core_exp_bits), .core_mod_bits(core_mod_bits),
    .eng_cls(eng_cls), .eng_idx(eng_idx), .eng_we(eng_we),
    .eng_wdata(eng_wdata), .eng_rdata(eng_rdata), .irq(irq)
  );

  int n_chk = 0, n_fail = 0;
  int beats = 0, starts = 0, start_in_load = 0, addr_err = 0;
  logic prev_v = 0;
  logic [31:0] exp_base = 0;
  logic [31:0] shadow [MW];

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction
  function automatic logic [13:0] maddr(input int w);
    return 14'h2000 | 14'(w << 2);
  endfunction
  function automatic int emap(input int c, input int i);
    return (i / 4) * 12 + c * 4 + i % 4;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic wait_load();
    int t = 0;
    while (rd_req && t < 20000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk); core_done = 1;
    @(negedge clk); core_done = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // Memory responder and monitor
  always @(negedge clk) begin
    if (prev_v) beats++;
    if (core_start) begin starts++; if (rd_req) start_in_load++; end
    if (rd_req && rd_addr !== exp_base + 32'(beats) * 4) addr_err++;
    rd_valid = rd_req && ($urandom_range(0, 3) != 0);
    rd_data = pat(rd_addr);
    prev_v = rd_valid;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  task automatic run_load(input logic [31:0] b, input logic [31:0] len, input logic [1:0] t,
                          input int nexp, input string tag);
    int s0, bad;
    logic [31:0] v;
    s0 = starts;
    wr(A_CMD, 32'h30);
    wr(A_LEN, len);
    wr(A_BASE, b);
    exp_base = b; beats = 0; addr_err = 0; start_in_load = 0;
    wr(A_TRIG, {30'd0, t});
    wait_load();
    chk({tag, " R3 beat count"}, 32'(beats), 32'(nexp));
    chk({tag, " R3 address sequence errors"}, 32'(addr_err), 0);
    chk({tag, " R4 start count"}, 32'(starts - s0), t[0] ? 1 : 0);
    chk({tag, " R4 start during load"}, 32'(start_in_load), 0);
    if (t[0]) begin
      rd(A_TRIG, v); chk({tag, " R11 trigger busy readback"}, v, {30'd0, t});
      pulse_done();
    end
    rd(A_TRIG, v); chk({tag, " R11 trigger idle readback"}, v, 0);
    wr(A_CMD, 32'h100);
    bad = 0;
    for (int k = 0; k < MW; k++) begin
      if (k < nexp) shadow[k] = pat(b + 32'(k) * 4);
      if (k < nexp + 8 && (k < 16 || k >= nexp - 4 || ($urandom_range(0, 15) == 0))) begin
        rd(maddr(k), v);
        if (v !== shadow[k]) bad++;
      end
    end
    chk({tag, " R3 SRAM contents"}, 32'(bad), 0);
    wr(A_STS, 32'h2);
  endtask

  initial begin
    logic [31:0] v, x, b;
    int s0, b0, bad;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rd_req", 32'(rd_req), 0);
    chk("R1 core_start", 32'(core_start), 0);
    rd(A_STS, v); chk("R1 status", v, 0);
    rd(A_CMD, v); chk("R1 command", v, 0);
    rd(A_TRIG, v); chk("R1 trigger", v, 0);

    // R2
    for (int i = 0; i < 4; i++) begin
      x = $urandom; wr(A_CMD, x); rd(A_CMD, v); chk("R2 command", v, x);
      x = $urandom; wr(A_BASE, x); rd(A_BASE, v); chk("R2 base", v, x);
      x = $urandom; wr(A_LEN, x); rd(A_LEN, v); chk("R2 length", v, x);
      x = $urandom; wr(A_MASK, x); rd(A_MASK, v); chk("R2 mask", v, x);
      x = $urandom; wr(A_KLEN, x); rd(A_KLEN, v); chk("R2 key length", v, x);
      chk("R2 exponent bits", 32'(core_exp_bits), 32'(x[31:16]));
      chk("R2 modulus bits", 32'(core_mod_bits), 32'(x[15:0]));
    end
    wr(A_MASK, 0);

    // R9 host window
    wr(A_CMD, 32'h100);
    for (int w = 0; w < MW; w++) begin
      shadow[w] = 32'hC0DE0000 | 32'(w);
      wr(maddr(w), shadow[w]);
    end
    bad = 0;
    for (int i = 0; i < 24; i++) begin
      int w = $urandom_range(0, MW - 1);
      rd(maddr(w), v); if (v !== shadow[w]) bad++;
    end
    chk("R9 host readback mismatches", 32'(bad), 0);
    rd(maddr(1535), v); chk("R9 last word", v, shadow[1535]);
    rd(maddr(1600), v); chk("R9 beyond capacity", v, 0);
    wr(A_CMD, 32'h30);
    rd(maddr(7), v); chk("R9 engine-owned read", v, 0);
    wr(maddr(5), 32'hDEAD0005);
    wr(A_CMD, 32'h100);
    rd(maddr(5), v); chk("R9 engine-owned write dropped", v, shadow[5]);

    // R10 engine port
    wr(A_CMD, 32'h30);
    bad = 0;
    for (int i = 0; i < 30; i++) begin
      int c = $urandom_range(0, 2);
      int j = $urandom_range(0, 511);
      @(negedge clk); eng_cls = 2'(c); eng_idx = 9'(j);
      #1 if (eng_rdata !== shadow[emap(c, j)]) bad++;
    end
    chk("R10 engine mapping mismatches", 32'(bad), 0);
    @(negedge clk); eng_cls = 2; eng_idx = 511;
    #1 chk("R10 data class top word", eng_rdata, shadow[1535]);
    @(negedge clk); eng_cls = 1; eng_idx = 6; eng_we = 1; eng_wdata = 32'hBEEF0018;
    @(negedge clk); eng_we = 0;
    shadow[18] = 32'hBEEF0018;
    wr(A_CMD, 32'h100);
    rd(maddr(18), v); chk("R10 engine write lands at word 18", v, 32'hBEEF0018);
    @(negedge clk); eng_cls = 0; eng_idx = 0; eng_we = 1; eng_wdata = 32'h11111111;
    @(negedge clk); eng_we = 0;
    rd(maddr(0), v); chk("R10 engine write in host mode dropped", v, shadow[0]);

    // R3 partial load, no start; odd length floors
    b = $urandom & 32'hFFFF_FFFC;
    run_load(b, 32'd163, 2'b10, 40, "partial");

    // R3 clipped full load with start, R8 busy trigger ignored, R5 R7
    b = $urandom & 32'hFFFF_FFFC;
    s0 = starts;
    wr(A_CMD, 32'h30); wr(A_LEN, 32'h2000); wr(A_BASE, b);
    exp_base = b; beats = 0; addr_err = 0; start_in_load = 0;
    wr(A_TRIG, 32'h3);
    rd(A_TRIG, v); chk("R11 trigger during load", v, 32'h3);
    wr(A_TRIG, 32'h1);
    wait_load();
    chk("R3 clipped beat count", 32'(beats), MW);
    chk("R3 clipped address errors", 32'(addr_err), 0);
    chk("R4 single start after load", 32'(starts - s0), 1);
    chk("R4 no start in load", 32'(start_in_load), 0);
    b0 = beats;
    wr(A_TRIG, 32'h2);
    repeat (4) @(negedge clk);
    chk("R8 busy trigger ignored rd_req", 32'(rd_req), 0);
    chk("R8 busy trigger ignored beats", 32'(beats), 32'(b0));
    rd(A_TRIG, v); chk("R11 trigger during run", v, 32'h3);
    wr(A_MASK, 0);
    pulse_done();
    rd(A_STS, v); chk("R5 done sets status", v, 32'h2);
    chk("R7 irq masked", 32'(irq), 0);
    wr(A_MASK, 32'h2);
    chk("R7 irq unmasked", 32'(irq), 1);
    rd(A_TRIG, v); chk("R11 trigger after done", v, 0);
    wr(A_CMD, 32'h100);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      int w = (i == 0) ? MW - 1 : $urandom_range(0, MW - 1);
      rd(maddr(w), v); if (v !== pat(b + 32'(w) * 4)) bad++;
    end
    for (int k = 0; k < MW; k++) shadow[k] = pat(b + 32'(k) * 4);
    chk("R3 full load contents", 32'(bad), 0);

    // R6 write-one-to-clear
    wr(A_STS, 0);
    rd(A_STS, v); chk("R6 write zero keeps flag", v, 32'h2);
    wr(A_STS, 32'h2);
    rd(A_STS, v); chk("R6 write one clears", v, 0);
    chk("R7 irq after clear", 32'(irq), 0);
    s0 = starts;
    wr(A_TRIG, 32'h1);
    chk("R4 start-only pulse", 32'(core_start), 1);
    chk("R4 start-only no read", 32'(rd_req), 0);
    @(negedge clk);
    chk("R4 pulse one cycle", 32'(core_start), 0);
    bus_wr = 1; bus_addr = A_STS; bus_wdata = 32'h2; core_done = 1;
    @(negedge clk); bus_wr = 0; core_done = 0;
    rd(A_STS, v); chk("R6 set wins over clear", v, 32'h2);
    chk("R7 irq on set", 32'(irq), 1);
    wr(A_STS, 32'h2);

    // R5 done while idle ignored
    pulse_done();
    rd(A_STS, v); chk("R5 idle done ignored", v, 0);
    chk("R5 idle done no irq", 32'(irq), 0);

    // R8 stop
    s0 = starts;
    wr(A_CMD, 32'h30); wr(A_LEN, 32'h1800);
    exp_base = 32'h1000; beats = 0; addr_err = 0;
    wr(A_BASE, 32'h1000);
    wr(A_TRIG, 32'h3);
    repeat (10) @(negedge clk);
    wr(A_TRIG, 0);
    chk("R8 stop drops rd_req", 32'(rd_req), 0);
    rd(A_TRIG, v); chk("R8 stop clears trigger", v, 0);
    repeat (20) @(negedge clk);
    chk("R8 no start after stop", 32'(starts - s0), 0);
    pulse_done();
    rd(A_STS, v); chk("R8 done after stop ignored", v, 0);
    for (int k = 0; k < MW; k++) if (k < beats) shadow[k] = pat(32'h1000 + 32'(k) * 4);
    run_load(32'h2000, 32'd16, 2'b10, 4, "after-stop R8");

    // random loads
    for (int i = 0; i < 4; i++) begin
      int n = $urandom_range(1, 64);
      b = $urandom & 32'hFFFF_FFFC;
      run_load(b, 32'(n * 4), ($urandom_range(0, 1) != 0) ? 2'b11 : 2'b10, n, "random R3");
    end

    summary();
    $finish;
  end
endmodule